// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a list of memory segments, each given as a 32-bit start address and a byte length, into the descriptor table that a DMA engine walks. It carves every segment into chunks so that no chunk spans a 64 KB address boundary. Each chunk becomes one 16-byte descriptor, written with the most significant byte of each 32-bit word first. The last descriptor of the list carries an end-of-list flag. When the list ends, the block reports how many descriptors it produced.

Segments arrive on a valid/ready stream, one per handshake, with a flag on the final segment of the list. A segment is taken on a cycle where `seg_valid` and `seg_ready` are both high. `seg_ready` drops while the block is splitting a segment or waiting for a descriptor to drain. Descriptors leave on a second valid/ready stream, each tagged with its table slot. While `ent_valid` is high and `ent_ready` is low, the descriptor and its slot are held unchanged. A downstream writer can stall the block for any number of cycles without loss.

The table holds a fixed number of descriptors. If a list needs more, the build is abandoned. Descriptors already sent are then void, and the completion report asks the caller to move the data by programmed I/O instead. A zero-length segment ends the list early.

Top module: `sgl_table_builder`

## Requirements
- R1: After reset `seg_ready` is 1, `ent_valid` is 0 and `done` is 0.
- R2: Each chunk length is the smaller of the bytes left in the segment and 65536 minus the low 16 address bits. Chunks of one segment follow one another in address order, and a 32-bit address wraps to 0. No descriptor's address plus its length crosses a 64 KB boundary.
- R3: A descriptor's length field holds the low 16 bits of the chunk length, so a full 65536-byte chunk is encoded as 0.
- R4: Descriptor byte k sits at `ent_bytes[8k+7:8k]`. Bytes 0-3 and 8-11 are zero. Bytes 4-7 hold the chunk address, most significant byte first. Byte 12 is `{eol, 7'b0}` and byte 13 is zero. Bytes 14-15 hold the length field, most significant byte first.
- R5: The end-of-list bit (bit 7 of byte 12, `ent_bytes[103]`) is set on the final descriptor of a successful list and clear on every other descriptor.
- R6: Descriptors leave with `ent_index` counting 0, 1, 2, ... in handshake order. On a successful list, `entry_count` at `done` equals the number of descriptors sent.
- R7: A list needing exactly `MAX_ENTRIES` (64) chunks completes normally. Needing one more aborts the build: no further descriptors are sent, later segments of the list are accepted and dropped up to the last one, and `done` carries `fallback` = 1 with `entry_count` = 0.
- R8: A zero-length segment ends the list. It and every later segment of the list are accepted without producing descriptors. `entry_count` reports the descriptors made before it, and a list whose first segment is zero-length reports 0 with `fallback` = 0.
- R9: While `ent_valid` is high and `ent_ready` is low, `ent_valid`, `ent_bytes` and `ent_index` stay unchanged into the next cycle.
- R10: `done` is a one-cycle pulse, issued once per list, with `entry_count` and `fallback` valid in that same cycle. `fallback` is 1 only for an aborted list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Block can take a segment |
| seg_addr | input | 32 | Segment start address |
| seg_len | input | LEN_W | Segment length in bytes (0 ends the list) |
| seg_last | input | 1 | Final segment of the list |
| ent_valid | output | 1 | Descriptor offered |
| ent_ready | input | 1 | Writer accepts the descriptor |
| ent_index | output | IDX_W | Table slot of the descriptor |
| ent_bytes | output | 128 | Descriptor bytes, byte k at bits 8k+7:8k |
| done | output | 1 | List finished (one-cycle pulse) |
| entry_count | output | CNT_W | Descriptors in the finished table |
| fallback | output | 1 | Table overflowed; use programmed I/O |

## Verification
The bound checker watches the following on every cycle:
- every offered descriptor has zero pad bytes and does not reach past a 64 KB boundary;
- offered descriptors stay stable under back-pressure;
- slot numbers run in handshake order and match the final count;
- an end-of-list handshake is followed by a clean `done`;
- an aborted list always reports a count of zero.

Only the bench's scenarios can show the following:
- that chunk lengths follow the splitting rule for particular alignments;
- that a full 64 KB chunk encodes as zero;
- that exactly 64 chunks succeed where 65 abort;
- that segments after a zero-length or overflowing one are consumed without output.

// File: rtl/sgl_pkg.sv
`timescale 1ns/1ps
package sgl_pkg;
  localparam int SEG_AW  = 32;
  localparam int CHUNK_W = 17;
  localparam int DESC_W  = 128;

  typedef enum logic [1:0] {
    ST_TAKE  = 2'd0,
    ST_SPLIT = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FLUSH = 2'd3
  } bld_state_e;
endpackage

// File: rtl/sgl_chunker.sv
`timescale 1ns/1ps
// Picks the next chunk: what is left of the segment, capped at the
// distance to the next 64 KB boundary.
module sgl_chunker #(
  parameter int LEN_W = 24
) (
  input  logic [15:0]                 addr_lo,
  input  logic [LEN_W-1:0]            rem,
  output logic [sgl_pkg::CHUNK_W-1:0] chunk_len,
  output logic                        tail
);
  localparam int CW = sgl_pkg::CHUNK_W;

  logic [CW-1:0] room;

  always_comb begin
    room = 17'h10000 - {1'b0, addr_lo};
    tail = (rem <= LEN_W'(room));
    chunk_len = tail ? rem[CW-1:0] : room;
  end
endmodule

// File: rtl/sgl_desc_fmt.sv
`timescale 1ns/1ps
// Packs one chunk into a 16-byte descriptor. Each 32-bit word is laid out
// most significant byte first.
module sgl_desc_fmt (
  input  logic [31:0]                addr,
  input  logic [15:0]                len_field,
  input  logic                       eol,
  output logic [sgl_pkg::DESC_W-1:0] bytes
);
  logic [31:0] word [4];

  always_comb begin
    word[0] = '0;
    word[1] = addr;
    word[2] = '0;
    word[3] = {eol, 15'd0, len_field};
  end

  for (genvar wi = 0; wi < 4; wi++) begin : g_word
    for (genvar bi = 0; bi < 4; bi++) begin : g_byte
      assign bytes[(wi*4+bi)*8 +: 8] = word[wi][31-bi*8 -: 8];
    end
  end
endmodule

// File: rtl/sgl_slot.sv
`timescale 1ns/1ps
// One-deep holding slot. A chunk stays here until the next chunk or the
// end of the list shows whether it is the final descriptor.
module sgl_slot #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic [31:0]      in_addr,
  input  logic [15:0]      in_len,
  input  logic [IDX_W-1:0] in_idx,
  output logic             vld,
  output logic [31:0]      addr,
  output logic [15:0]      len,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      addr <= '0;
      len  <= '0;
      idx  <= '0;
    end else if (clear) begin
      vld <= 1'b0;
    end else if (load) begin
      vld  <= 1'b1;
      addr <= in_addr;
      len  <= in_len;
      idx  <= in_idx;
    end
  end
endmodule

// File: rtl/sgl_table_builder.sv
`timescale 1ns/1ps
module sgl_table_builder #(
  parameter  int MAX_ENTRIES = 64,
  parameter  int LEN_W       = 24,
  localparam int IDX_W       = $clog2(MAX_ENTRIES),
  localparam int CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seg_valid,
  output logic               seg_ready,
  input  logic [31:0]        seg_addr,
  input  logic [LEN_W-1:0]   seg_len,
  input  logic               seg_last,
  output logic               ent_valid,
  input  logic               ent_ready,
  output logic [IDX_W-1:0]   ent_index,
  output logic [127:0]       ent_bytes,
  output logic               done,
  output logic [CNT_W-1:0]   entry_count,
  output logic               fallback
);
  import sgl_pkg::*;

  bld_state_e           state;
  logic [31:0]          cur_addr;
  logic [LEN_W-1:0]     cur_rem;
  logic                 last_q;
  logic                 aborted;
  logic [CNT_W-1:0]     made;
  logic                 done_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 fb_q;

  logic [CHUNK_W-1:0]   chunk_len;
  logic                 tail;
  logic                 full;
  logic                 slot_load;
  logic                 slot_clear;
  logic                 slot_vld;
  logic [31:0]          slot_addr;
  logic [15:0]          slot_len;
  logic [IDX_W-1:0]     slot_idx;
  logic                 eol;

  sgl_chunker #(.LEN_W(LEN_W)) u_chunker (
    .addr_lo   (cur_addr[15:0]),
    .rem       (cur_rem),
    .chunk_len (chunk_len),
    .tail      (tail)
  );

  always_comb begin
    full       = (made == CNT_W'(MAX_ENTRIES));
    seg_ready  = (state == ST_TAKE) || (state == ST_DRAIN);
    ent_valid  = (state == ST_FLUSH) || ((state == ST_SPLIT) && slot_vld && !full);
    eol        = (state == ST_FLUSH);
    slot_load  = (state == ST_SPLIT) && !full && (!slot_vld || ent_ready);
    slot_clear = ((state == ST_SPLIT) && full) || ((state == ST_FLUSH) && ent_ready);
  end

  sgl_slot #(.IDX_W(IDX_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (slot_load),
    .clear   (slot_clear),
    .in_addr (cur_addr),
    .in_len  (chunk_len[15:0]),
    .in_idx  (made[IDX_W-1:0]),
    .vld     (slot_vld),
    .addr    (slot_addr),
    .len     (slot_len),
    .idx     (slot_idx)
  );

  sgl_desc_fmt u_fmt (
    .addr      (slot_addr),
    .len_field (slot_len),
    .eol       (eol),
    .bytes     (ent_bytes)
  );

  assign ent_index   = slot_idx;
  assign done        = done_q;
  assign entry_count = cnt_q;
  assign fallback    = fb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_TAKE;
      cur_addr <= '0;
      cur_rem  <= '0;
      last_q   <= 1'b0;
      aborted  <= 1'b0;
      made     <= '0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      fb_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_TAKE: begin
          if (seg_valid) begin
            if (seg_len == '0) begin
              if (!seg_last) begin
                state <= ST_DRAIN;
              end else if (slot_vld) begin
                state <= ST_FLUSH;
              end else begin
                done_q <= 1'b1;
                cnt_q  <= '0;
                fb_q   <= 1'b0;
              end
            end else begin
              cur_addr <= seg_addr;
              cur_rem  <= seg_len;
              last_q   <= seg_last;
              state    <= ST_SPLIT;
            end
          end
        end
        ST_SPLIT: begin
          if (full) begin
            made <= '0;
            if (last_q) begin
              done_q <= 1'b1;
              cnt_q  <= '0;
              fb_q   <= 1'b1;
              state  <= ST_TAKE;
            end else begin
              aborted <= 1'b1;
              state   <= ST_DRAIN;
            end
          end else if (slot_load) begin
            cur_addr <= cur_addr + 32'(chunk_len);
            cur_rem  <= cur_rem - LEN_W'(chunk_len);
            made     <= made + CNT_W'(1);
            if (tail) state <= last_q ? ST_FLUSH : ST_TAKE;
          end
        end
        ST_DRAIN: begin
          if (seg_valid && seg_last) begin
            if (aborted) begin
              aborted <= 1'b0;
              done_q  <= 1'b1;
              cnt_q   <= '0;
              fb_q    <= 1'b1;
              state   <= ST_TAKE;
            end else if (slot_vld) begin
              state <= ST_FLUSH;
            end else begin
              done_q <= 1'b1;
              cnt_q  <= '0;
              fb_q   <= 1'b0;
              state  <= ST_TAKE;
            end
          end
        end
        ST_FLUSH: begin
          if (ent_ready) begin
            done_q <= 1'b1;
            cnt_q  <= made;
            fb_q   <= 1'b0;
            made   <= '0;
            state  <= ST_TAKE;
          end
        end
        default: state <= ST_TAKE;
      endcase
    end
  end
endmodule

// File: rtl/sgl_table_builder_chk.sv
`timescale 1ns/1ps
module sgl_table_builder_chk #(
  parameter  int MAX_ENTRIES = 64,
  localparam int IDX_W       = $clog2(MAX_ENTRIES),
  localparam int CNT_W       = $clog2(MAX_ENTRIES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ent_valid,
  input logic             ent_ready,
  input logic [IDX_W-1:0] ent_index,
  input logic [127:0]     ent_bytes,
  input logic             done,
  input logic [CNT_W-1:0] entry_count,
  input logic             fallback
);
  logic [CNT_W-1:0] seen;
  logic [15:0]      addr_lo;
  logic [15:0]      len_fld;
  logic [16:0]      len_dec;
  logic [17:0]      end_off;
  logic             eol_bit;

  always_comb begin
    addr_lo = {ent_bytes[6*8 +: 8], ent_bytes[7*8 +: 8]};
    len_fld = {ent_bytes[14*8 +: 8], ent_bytes[15*8 +: 8]};
    len_dec = (len_fld == 16'd0) ? 17'h10000 : {1'b0, len_fld};
    end_off = {2'b00, addr_lo} + {1'b0, len_dec};
    eol_bit = ent_bytes[12*8 + 7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       seen <= '0;
    else if (done)                    seen <= '0;
    else if (ent_valid && ent_ready)  seen <= seen + CNT_W'(1);
  end

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !ent_ready |=> ent_valid && $stable(ent_bytes) && $stable(ent_index));

  a_r2_no_boundary_cross: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> end_off <= 18'h10000);

  a_r4_pad_bytes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> (ent_bytes[31:0] == 32'd0) && (ent_bytes[95:64] == 32'd0)
                  && (ent_bytes[102:96] == 7'd0) && (ent_bytes[111:104] == 8'd0));

  a_r6_index_order: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> ent_index == seen[IDX_W-1:0]);

  a_r6_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fallback |-> entry_count == seen);

  a_r5_eol_closes_list: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && ent_ready && eol_bit |=> done && !fallback);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_fallback_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done && fallback |-> entry_count == '0);
endmodule

bind sgl_table_builder sgl_table_builder_chk #(.MAX_ENTRIES(MAX_ENTRIES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ent_valid   (ent_valid),
  .ent_ready   (ent_ready),
  .ent_index   (ent_index),
  .ent_bytes   (ent_bytes),
  .done        (done),
  .entry_count (entry_count),
  .fallback    (fallback)
);

// File: tb/tb_sgl_table_builder.sv
`timescale 1ns/1ps
module tb_sgl_table_builder;
  localparam int MAXE = 64;
  localparam int LW   = 24;

  // {address, length, expected descriptor count}
  localparam logic [63:0] VEC [8] = '{
    {32'h0000_1000, 24'h000100, 8'd1},
    {32'h0000_FF00, 24'h000200, 8'd2},
    {32'h0001_0000, 24'h010000, 8'd1},
    {32'h0002_8000, 24'h028000, 8'd3},
    {32'h1234_FFFF, 24'h000002, 8'd2},
    {32'h0000_0000, 24'h000001, 8'd1},
    {32'hFFFF_FFF0, 24'h000020, 8'd2},
    {32'h0003_0000, 24'h3F0000, 8'd63}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          seg_valid;
  logic          seg_ready;
  logic [31:0]   seg_addr;
  logic [LW-1:0] seg_len;
  logic          seg_last;
  logic          ent_valid;
  logic          ent_ready;
  logic [5:0]    ent_index;
  logic [127:0]  ent_bytes;
  logic          done;
  logic [6:0]    entry_count;
  logic          fallback;

  always #4 clk = ~clk;

  sgl_table_builder #(.MAX_ENTRIES(MAXE), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_index(ent_index),
    .ent_bytes(ent_bytes), .done(done), .entry_count(entry_count),
    .fallback(fallback)
  );

  int checks = 0;
  int fails  = 0;

  logic [31:0] sa [16];
  logic [LW-1:0] sl [16];
  int ns;
  logic [31:0] ea [80];
  int el [80];
  int en;
  bit eovf;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_entry(input logic [31:0] a, input logic [15:0] lf,
                                           input bit e);
    logic [127:0] r;
    r = '0;
    r[4*8 +: 8]  = a[31:24];
    r[5*8 +: 8]  = a[23:16];
    r[6*8 +: 8]  = a[15:8];
    r[7*8 +: 8]  = a[7:0];
    r[12*8 +: 8] = {e, 7'd0};
    r[14*8 +: 8] = lf[15:8];
    r[15*8 +: 8] = lf[7:0];
    return r;
  endfunction

  task automatic build_model();
    bit stop;
    stop = 0;
    en = 0;
    eovf = 0;
    for (int i = 0; i < ns && !stop; i++) begin
      int rem;
      logic [31:0] a;
      if (sl[i] == '0) begin
        stop = 1;
      end else begin
        rem = int'(sl[i]);
        a = sa[i];
        while (rem > 0 && !stop) begin
          int room;
          int c;
          room = 65536 - int'(a[15:0]);
          c = (rem < room) ? rem : room;
          if (en >= MAXE) begin
            eovf = 1;
            stop = 1;
          end else begin
            ea[en] = a;
            el[en] = c;
            en++;
            a = a + 32'(c);
            rem = rem - c;
          end
        end
      end
    end
  endtask

  task automatic run_case(input string name, input int stall, input int exp_cnt,
                          input bit exp_fb, input string req);
    int got;
    int cyc;
    bit fin;
    bit hv;
    logic [127:0] held;
    build_model();
    got = 0; cyc = 0; fin = 0; hv = 0; held = '0;
    fork
      begin
        bit acc;
        @(negedge clk);
        for (int i = 0; i < ns; i++) begin
          seg_valid = 1'b1;
          seg_addr  = sa[i];
          seg_len   = sl[i];
          seg_last  = (i == ns - 1);
          do begin
            acc = seg_ready;
            @(negedge clk);
          end while (!acc);
        end
        seg_valid = 1'b0;
        seg_last  = 1'b0;
      end
      begin
        while (!fin) begin
          @(negedge clk);
          cyc++;
          if (hv) begin
            if (ent_valid)
              chk(ent_bytes == held, {name, " R9 held descriptor"}, ent_bytes, held);
            hv = 0;
          end
          ent_ready = (stall == 0) ? 1'b1 : ((cyc % 3) != 0);
          if (done) begin
            chk(entry_count == 7'(exp_cnt), {name, " ", req, " count"},
                128'(entry_count), 128'(exp_cnt));
            chk(fallback == exp_fb, {name, " R7 R10 fallback"}, 128'(fallback), 128'(exp_fb));
            if (!exp_fb)
              chk(got == exp_cnt, {name, " R6 descriptors sent"}, 128'(got), 128'(exp_cnt));
            fin = 1;
          end else if (ent_valid) begin
            if (ent_ready) begin
              if (got < 80) begin
                chk(ent_index == 6'(got), {name, " R6 slot index"},
                    128'(ent_index), 128'(got));
                chk(ent_bytes == mk_entry(ea[got], 16'(el[got]), (got == en - 1) && !eovf),
                    {name, " R2 R3 R4 R5 descriptor"}, ent_bytes,
                    mk_entry(ea[got], 16'(el[got]), (got == en - 1) && !eovf));
              end
              got++;
            end else begin
              held = ent_bytes;
              hv = 1;
            end
          end
        end
      end
    join
    @(negedge clk);
    chk(done == 1'b0, {name, " R10 single pulse"}, 128'(done), 128'd0);
    ent_ready = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    seg_valid = 1'b0;
    seg_addr = '0;
    seg_len = '0;
    seg_last = 1'b0;
    ent_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(seg_ready == 1'b1, "R1 seg_ready after reset", 128'(seg_ready), 128'd1);
    chk(ent_valid == 1'b0, "R1 ent_valid after reset", 128'(ent_valid), 128'd0);
    chk(done == 1'b0, "R1 done after reset", 128'(done), 128'd0);

    for (int v = 0; v < 8; v++) begin
      ns = 1;
      sa[0] = VEC[v][63:32];
      sl[0] = VEC[v][31:8];
      run_case($sformatf("vec%0d", v), v % 2, int'(VEC[v][7:0]), 1'b0, "R2 R6");
    end

    // R7: exactly 64 chunks succeeds
    ns = 1; sa[0] = 32'h0001_0000; sl[0] = 24'h400000;
    run_case("cap64", 0, 64, 1'b0, "R7");
    // R7: one chunk too many aborts
    ns = 1; sa[0] = 32'h0001_0000; sl[0] = 24'h400001;
    run_case("cap65", 1, 0, 1'b1, "R7");
    // R7: overflow reached in a later segment
    ns = 2; sa[0] = 32'h0; sl[0] = 24'h400000; sa[1] = 32'h100; sl[1] = 24'h10;
    run_case("cap_2seg", 0, 0, 1'b1, "R7");
    // R7: overflow with extra segments to drop afterwards
    ns = 3; sa[0] = 32'h0; sl[0] = 24'h400000; sa[1] = 32'h100; sl[1] = 24'h10;
    sa[2] = 32'h200; sl[2] = 24'h10;
    run_case("cap_drain", 0, 0, 1'b1, "R7");
    // multi-segment list under back-pressure
    ns = 3;
    sa[0] = 32'h0000_0100; sl[0] = 24'h10;
    sa[1] = 32'h0002_FFF0; sl[1] = 24'h20;
    sa[2] = 32'h0000_5000; sl[2] = 24'h010000;
    run_case("multi", 1, 5, 1'b0, "R6");
    // R8: zero-length segment ends the list early
    ns = 3;
    sa[0] = 32'h0000_4000; sl[0] = 24'h40;
    sa[1] = 32'h0000_8000; sl[1] = 24'h0;
    sa[2] = 32'h0000_9000; sl[2] = 24'h80;
    run_case("zstop", 0, 1, 1'b0, "R8");
    // R8: empty list
    ns = 1; sa[0] = 32'h0; sl[0] = 24'h0;
    run_case("empty", 0, 0, 1'b0, "R8");
    // R8: zero-length first segment, more data after it
    ns = 2; sa[0] = 32'h0; sl[0] = 24'h0; sa[1] = 32'h100; sl[1] = 24'h10;
    run_case("zfirst", 1, 0, 1'b0, "R8");
    // recovery after an abort
    ns = 1; sa[0] = 32'h0000_FFF8; sl[0] = 24'h10;
    run_case("recover", 0, 2, 1'b0, "R6");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule